// File: doc/BRIEF.md
# RISC Integer Execute Unit with Built-in Decode

This block is the integer execute stage of a classic 32-bit load/store RISC core. It takes the raw operation fields of an instruction: the 6-bit major opcode, the 6-bit function code and the 5-bit shift count. It also takes the two register operands and the 16-bit immediate. It decodes the operation itself and returns a 32-bit result together with an illegal-operation flag. There is no separate ALU-control input: the opcode and function encodings are matched directly.

Register-format work uses major opcode 0, and there the function code selects add, subtract, AND, OR, NOR, signed set-less-than and three shifts by a constant count. Immediate-format work covers add, signed set-less-than, AND, OR and load-upper. Sign or zero extension of the immediate is chosen per opcode. The output is combinational by default. Setting `REG_OUT` to 1 adds one output register stage that clears on reset.

Top module: `int_exec_alu`

## Requirements
- R1: With opcode 0x00, function 0x20 returns src_a + src_b and function 0x22 returns src_a - src_b, both wrapping modulo 2^32 with no overflow indication (illegal stays 0).
- R2: With opcode 0x00, function 0x24 returns src_a AND src_b, 0x25 returns src_a OR src_b, and 0x27 returns NOT(src_a OR src_b).
- R3: With opcode 0x00 and function 0x2A, the result is 1 when src_a is less than src_b as signed two's-complement values, else 0; bits 31:1 are always 0.
- R4: With opcode 0x00, function 0x00 shifts src_b left, 0x02 shifts it right with zero fill, and 0x03 shifts it right with sign fill. The count is taken from shamt, and src_a is ignored.
- R5: Opcode 0x08 returns src_a plus the sign-extended immediate. Opcode 0x0A returns 1 when src_a is less than the sign-extended immediate (signed), else 0.
- R6: Opcode 0x0C returns src_a AND the zero-extended immediate; opcode 0x0D returns src_a OR the zero-extended immediate.
- R7: Opcode 0x0F returns the immediate in bits 31:16 with bits 15:0 cleared; src_a, src_b and funct are ignored.
- R8: Any other opcode, or opcode 0x00 with any other function code, gives result 0 with illegal = 1. Every supported operation gives illegal = 0.
- R9: With REG_OUT = 1, result and illegal appear one clock after the inputs and read 0 while rst_n is low. With REG_OUT = 0 they follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low reset of the output register |
| opcode | input | 6 | Major opcode field |
| funct | input | 6 | Function field, used when opcode is 0 |
| shamt | input | 5 | Constant shift count |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand, the shifted value for shifts |
| imm | input | 16 | Immediate field |
| result | output | 32 | Operation result |
| illegal | output | 1 | Set when the operation is not supported |

## Verification
On every cycle, the assertions check that an illegal flag always comes with a zero result and that set-less-than results never set bits above bit 0. They also check that a difference added back to the subtrahend returns the minuend, that NOR output is the exact complement of the OR, that load-upper leaves the low half clear, and, in the registered variant, that the output is the previous cycle's computed value. Signed against unsigned comparison at the sign boundary, the choice between sign and zero extension, shift fill bits and wraparound values can only be shown by the bench's vectors. The same holds for the reset value of the registered stage.

// File: rtl/int_exec_alu.sv
module int_exec_alu #(
  parameter int DW      = 32,
  parameter int IW      = 16,
  parameter int OPW     = 6,
  parameter int SW      = 5,
  parameter bit REG_OUT = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  input  logic [OPW-1:0] funct,
  input  logic [SW-1:0]  shamt,
  input  logic [DW-1:0]  src_a,
  input  logic [DW-1:0]  src_b,
  input  logic [IW-1:0]  imm,
  output logic [DW-1:0]  result,
  output logic           illegal
);
  localparam logic [OPW-1:0] OP_REG  = 6'h00;
  localparam logic [OPW-1:0] OP_ADDI = 6'h08;
  localparam logic [OPW-1:0] OP_SLTI = 6'h0A;
  localparam logic [OPW-1:0] OP_ANDI = 6'h0C;
  localparam logic [OPW-1:0] OP_ORI  = 6'h0D;
  localparam logic [OPW-1:0] OP_LUI  = 6'h0F;
  localparam logic [OPW-1:0] FN_SLL  = 6'h00;
  localparam logic [OPW-1:0] FN_SRL  = 6'h02;
  localparam logic [OPW-1:0] FN_SRA  = 6'h03;
  localparam logic [OPW-1:0] FN_ADD  = 6'h20;
  localparam logic [OPW-1:0] FN_SUB  = 6'h22;
  localparam logic [OPW-1:0] FN_AND  = 6'h24;
  localparam logic [OPW-1:0] FN_OR   = 6'h25;
  localparam logic [OPW-1:0] FN_NOR  = 6'h27;
  localparam logic [OPW-1:0] FN_SLT  = 6'h2A;
  localparam int             PAD     = DW - IW;

  wire [DW-1:0] imm_sx = {{PAD{imm[IW-1]}}, imm};
  wire [DW-1:0] imm_zx = {{PAD{1'b0}}, imm};
  wire          lt_reg = $signed(src_a) < $signed(src_b);
  wire          lt_imm = $signed(src_a) < $signed(imm_sx);
  wire [DW-1:0] sra_v  = DW'($signed(src_b) >>> shamt);

  logic [DW-1:0] comb_res;
  logic          comb_ill;

  always_comb begin
    comb_res = '0;
    comb_ill = 1'b0;
    case (opcode)
      OP_REG: begin
        case (funct)
          FN_ADD:  comb_res = src_a + src_b;
          FN_SUB:  comb_res = src_a - src_b;
          FN_AND:  comb_res = src_a & src_b;
          FN_OR:   comb_res = src_a | src_b;
          FN_NOR:  comb_res = ~(src_a | src_b);
          FN_SLT:  comb_res = {{(DW-1){1'b0}}, lt_reg};
          FN_SLL:  comb_res = src_b << shamt;
          FN_SRL:  comb_res = src_b >> shamt;
          FN_SRA:  comb_res = sra_v;
          default: comb_ill = 1'b1;
        endcase
      end
      OP_ADDI: comb_res = src_a + imm_sx;
      OP_SLTI: comb_res = {{(DW-1){1'b0}}, lt_imm};
      OP_ANDI: comb_res = src_a & imm_zx;
      OP_ORI:  comb_res = src_a | imm_zx;
      OP_LUI:  comb_res = {imm, {PAD{1'b0}}};
      default: comb_ill = 1'b1;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result  <= '0;
          illegal <= 1'b0;
        end else begin
          result  <= comb_res;
          illegal <= comb_ill;
        end
      end

      a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (result == $past(comb_res)) && (illegal == $past(comb_ill)));
    end else begin : g_comb
      assign result  = comb_res;
      assign illegal = comb_ill;
    end
  endgenerate

  a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0));

  a_r3_slt_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ((opcode == OP_REG && funct == FN_SLT) || opcode == OP_SLTI)
      |-> (comb_res[DW-1:1] == '0 && !comb_ill));

  a_r1_sub_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_REG && funct == FN_SUB) |-> (comb_res + src_b == src_a));

  a_r2_nor_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_REG && funct == FN_NOR)
      |-> (((comb_res & (src_a | src_b)) == '0) && ((comb_res | src_a | src_b) == '1)));

  a_r7_lui_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_LUI) |-> (comb_res[IW-1:0] == '0 && comb_res[DW-1:DW-IW] == imm));
endmodule

// File: tb/int_exec_alu_tb.sv
module int_exec_alu_tb;
  typedef struct packed {
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic [31:0] exp;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 6'h20, 5'd0,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 32'h80000000, 1'b0, 4'd1}, // R1
    '{6'h00, 6'h20, 5'd0,  32'hFFFFFFFF, 32'h00000002, 16'h0000, 32'h00000001, 1'b0, 4'd1}, // R1
    '{6'h00, 6'h22, 5'd0,  32'h00000005, 32'h00000007, 16'h0000, 32'hFFFFFFFE, 1'b0, 4'd1}, // R1
    '{6'h00, 6'h22, 5'd0,  32'h80000000, 32'h00000001, 16'h0000, 32'h7FFFFFFF, 1'b0, 4'd1}, // R1
    '{6'h00, 6'h24, 5'd0,  32'hF0F0F0F0, 32'hFF00FF00, 16'h0000, 32'hF000F000, 1'b0, 4'd2}, // R2
    '{6'h00, 6'h25, 5'd0,  32'hF0F0F0F0, 32'h0F0F0000, 16'h0000, 32'hFFFFF0F0, 1'b0, 4'd2}, // R2
    '{6'h00, 6'h27, 5'd0,  32'h0F0F0F0F, 32'hF0F00000, 16'h0000, 32'h0000F0F0, 1'b0, 4'd2}, // R2
    '{6'h00, 6'h2A, 5'd0,  32'hFFFFFFFF, 32'h00000001, 16'h0000, 32'h00000001, 1'b0, 4'd3}, // R3
    '{6'h00, 6'h2A, 5'd0,  32'h00000001, 32'hFFFFFFFF, 16'h0000, 32'h00000000, 1'b0, 4'd3}, // R3
    '{6'h00, 6'h2A, 5'd0,  32'h00000005, 32'h00000005, 16'h0000, 32'h00000000, 1'b0, 4'd3}, // R3
    '{6'h00, 6'h00, 5'd4,  32'hFFFFFFFF, 32'h00000003, 16'h0000, 32'h00000030, 1'b0, 4'd4}, // R4
    '{6'h00, 6'h02, 5'd31, 32'hFFFFFFFF, 32'h80000000, 16'h0000, 32'h00000001, 1'b0, 4'd4}, // R4
    '{6'h00, 6'h03, 5'd4,  32'h00000000, 32'h80000000, 16'h0000, 32'hF8000000, 1'b0, 4'd4}, // R4
    '{6'h00, 6'h03, 5'd4,  32'h00000000, 32'h40000000, 16'h0000, 32'h04000000, 1'b0, 4'd4}, // R4
    '{6'h00, 6'h00, 5'd0,  32'hAAAAAAAA, 32'h12345678, 16'h0000, 32'h12345678, 1'b0, 4'd4}, // R4
    '{6'h08, 6'h3F, 5'd0,  32'h00000010, 32'hDEADBEEF, 16'hFFFF, 32'h0000000F, 1'b0, 4'd5}, // R5
    '{6'h08, 6'h00, 5'd0,  32'h00000000, 32'h00000000, 16'h8000, 32'hFFFF8000, 1'b0, 4'd5}, // R5
    '{6'h0A, 6'h00, 5'd0,  32'hFFFFFFFE, 32'h00000000, 16'hFFFF, 32'h00000001, 1'b0, 4'd5}, // R5
    '{6'h0A, 6'h00, 5'd0,  32'h00000000, 32'h00000000, 16'hFFFF, 32'h00000000, 1'b0, 4'd5}, // R5
    '{6'h0C, 6'h00, 5'd0,  32'hFFFFFFFF, 32'h00000000, 16'h8001, 32'h00008001, 1'b0, 4'd6}, // R6
    '{6'h0D, 6'h00, 5'd0,  32'h12340000, 32'h00000000, 16'h8001, 32'h12348001, 1'b0, 4'd6}, // R6
    '{6'h0F, 6'h22, 5'd7,  32'h12345678, 32'h87654321, 16'hFFFF, 32'hFFFF0000, 1'b0, 4'd7}, // R7
    '{6'h0F, 6'h00, 5'd0,  32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1234, 32'h12340000, 1'b0, 4'd7}, // R7
    '{6'h23, 6'h20, 5'd0,  32'h00000001, 32'h00000001, 16'h0001, 32'h00000000, 1'b1, 4'd8}, // R8
    '{6'h00, 6'h21, 5'd0,  32'h00000001, 32'h00000001, 16'h0000, 32'h00000000, 1'b1, 4'd8}, // R8
    '{6'h00, 6'h01, 5'd3,  32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 32'h00000000, 1'b1, 4'd8}, // R8
    '{6'h02, 6'h00, 5'd0,  32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 32'h00000000, 1'b1, 4'd8}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = '0;
  logic [5:0]  funct = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm = '0;
  logic [31:0] res_r, res_c;
  logic        ill_r, ill_c;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  int_exec_alu #(.REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .shamt(shamt),
    .src_a(src_a), .src_b(src_b), .imm(imm), .result(res_r), .illegal(ill_r));

  int_exec_alu #(.REG_OUT(1'b0)) u_dut_comb (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .shamt(shamt),
    .src_a(src_a), .src_b(src_b), .imm(imm), .result(res_c), .illegal(ill_c));

  task automatic check(input string what, input int req, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    opcode = v.op; funct = v.fn; shamt = v.sh;
    src_a = v.a; src_b = v.b; imm = v.imm;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
      finish_run();
    end
  end

  initial begin
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    // R9: registered stage held at zero during reset
    check("reset result", 9, res_r, 32'h0);
    check("reset illegal", 9, {31'b0, ill_r}, 32'h0);
    // R9: combinational variant follows inputs regardless
    check("comb during reset", 9, res_c, 32'h80000000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #1;
      check($sformatf("comb vec %0d", i), int'(VECS[i].req), res_c, VECS[i].exp);
      check($sformatf("comb ill %0d", i), int'(VECS[i].req), {31'b0, ill_c}, {31'b0, VECS[i].ill});
      @(negedge clk);
      check($sformatf("reg vec %0d", i), int'(VECS[i].req), res_r, VECS[i].exp);
      check($sformatf("reg ill %0d", i), int'(VECS[i].req), {31'b0, ill_r}, {31'b0, VECS[i].ill});
    end

    // R9: registered output keeps the old value until the next edge
    @(negedge clk);
    apply(VECS[5]);
    @(negedge clk);
    apply(VECS[0]);
    #1;
    check("latency old value", 9, res_r, 32'hFFFFF0F0);
    check("latency comb new", 9, res_c, 32'h80000000);
    @(negedge clk);
    check("latency new value", 9, res_r, 32'h80000000);

    // R8: illegal flag clears on the next legal operation
    apply(VECS[23]);
    @(negedge clk);
    check("illegal set", 8, {31'b0, ill_r}, 32'h1);
    apply(VECS[2]);
    @(negedge clk);
    check("illegal cleared", 8, {31'b0, ill_r}, 32'h0);
    check("after illegal result", 1, res_r, 32'hFFFFFFFE);

    // R4: shift amount 31 left drops all but bit 0
    opcode = 6'h00; funct = 6'h00; shamt = 5'd31; src_a = 32'h0; src_b = 32'h00000003; imm = '0;
    #1;
    check("sll by 31", 4, res_c, 32'h80000000);

    // R9: mid-run reset clears the registered stage
    apply(VECS[25]);
    rst_n = 1'b0;
    #1;
    check("mid reset result", 9, res_r, 32'h0);
    check("mid reset illegal", 9, {31'b0, ill_r}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("post reset illegal", 8, {31'b0, ill_r}, 32'h1);

    finish_run();
  end
endmodule